// File: doc/BRIEF.md
# Sequential Shift and Rotate Unit with Condition Flags

This unit performs one of eight shift or rotate operations on an 8, 16 or 32-bit operand. The operations are arithmetic shift, logical shift, plain rotate and rotate through the extend bit, each either left or right. When the operation finishes, the unit reports the result and five condition flags: extend, negative, zero, overflow and carry. The shift amount comes from one of two sources. The first is a short immediate field, in which the value zero stands for eight. The second is a register value taken modulo 64. A separate memory-form input forces a single-bit shift of a 16-bit operand.

The datapath moves the operand by one bit position per clock. A `start` pulse latches every input. `busy` stays high while steps remain. `done` then pulses for one cycle, with the result and flags, which hold until the next operation completes. The per-step approach yields the flag rules directly: the carry is the last bit that left the operand, the overflow flag is sticky over any change of the most significant bit, and the rotate-through-extend ring is one bit longer than the operand. Operand bits above the selected size pass through unchanged.

Top module: `shr_unit`

## Requirements
- R1: With `cnt_is_reg`=0 the step count is `cnt_imm`, with 0 meaning 8. With `cnt_is_reg`=1 the step count is `cnt_reg[5:0]`, so register values are taken modulo 64.
- R2: `kind` encodes 00 arithmetic, 01 logical, 10 rotate through extend and 11 rotate. `left`=1 shifts toward the MSB and `left`=0 toward bit 0. `size` encodes 00 byte, 01 word, 10 long. Every combination gives the correct result for each count from 0 to 63.
- R3: Counts at or beyond the operand width stay correct. A logical shift gives zero. An arithmetic right shift fills the operand with the sign bit. A plain rotate is taken modulo the width. A rotate through extend is taken modulo the width plus one.
- R4: Bits of `opnd` above the selected size appear unchanged in `result`.
- R5: For the arithmetic and logical kinds, X and C both equal the last bit shifted out. With a zero count, X keeps `x_in` and C is 0.
- R6: For plain rotate, X always equals `x_in`. C equals the last bit rotated out, and C is 0 with a zero count.
- R7: For rotate through extend, X and C both equal the last bit rotated out. With a zero count, X keeps `x_in` and C equals `x_in`.
- R8: For an arithmetic left shift, V is 1 when the MSB at the selected size changed at any step. For every other operation V is 0.
- R9: N equals the result MSB at the selected size. Z is 1 exactly when the result bits within the selected size are all zero.
- R10: With `mem_form`=1 the unit shifts by exactly one bit at word size, whatever `size`, `cnt_is_reg`, `cnt_imm` and `cnt_reg` hold.
- R11: `done` is a single-cycle pulse that arrives count+1 clock cycles after the cycle in which `start` is accepted. `busy` is high until that pulse. `result` and the flags hold afterwards.
- R12: A `start` while `busy` is high is ignored. The running operation finishes with its own operands and timing, and no extra `done` follows.
- R13: While reset is held, `busy`, `done`, `result` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| opnd | input | 32 | Operand; bits above the size pass through |
| x_in | input | 1 | Incoming extend flag |
| kind | input | 2 | Operation type |
| left | input | 1 | Direction: 1 left, 0 right |
| size | input | 2 | Operand size |
| cnt_is_reg | input | 1 | Select register count instead of immediate |
| cnt_imm | input | 3 | Immediate count field (0 means 8) |
| cnt_reg | input | 32 | Register count value (used modulo 64) |
| mem_form | input | 1 | Single-bit word shift form |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Shifted or rotated value |
| x_out | output | 1 | Extend flag |
| n_out | output | 1 | Negative flag |
| z_out | output | 1 | Zero flag |
| v_out | output | 1 | Overflow flag |
| c_out | output | 1 | Carry flag |

## Verification
The hardest behaviour to reach from the ports is the rotation through the extend bit when the count runs past the operand width. In that case the incoming extend value travels through the operand and back into the flag, and a wrong ring length gives a result that only looks plausible. A second hard case is a register count of 64 or a multiple of it, which has to alias to the zero-count flag rules. The stimulus reaches both through register-count mode. It uses counts such as 9, 17, 33 and 64 on each size, with a nonzero extend input, and sweeps every kind, direction and size over counts from 0 to 63 against a bit-serial model.

// File: rtl/shr_pkg.sv
package shr_pkg;

  typedef enum logic [1:0] {
    K_ARITH = 2'b00,
    K_LOGIC = 2'b01,
    K_ROTX  = 2'b10,
    K_ROT   = 2'b11
  } shr_kind_e;

  typedef enum logic [1:0] {
    SZ_B = 2'b00,
    SZ_W = 2'b01,
    SZ_L = 2'b10,
    SZ_X = 2'b11
  } shr_size_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } shr_state_e;

  typedef struct packed {
    logic x;
    logic n;
    logic z;
    logic v;
    logic c;
  } shr_flags_t;

endpackage

// File: rtl/shr_count_dec.sv
module shr_count_dec #(
  parameter int CW   = 6,
  parameter int IMMW = 3
) (
  input  logic            use_reg,
  input  logic            mem_form,
  input  logic [IMMW-1:0] imm,
  input  logic [CW-1:0]   reg_val,
  output logic [CW-1:0]   cnt
);

  localparam logic [CW-1:0] IMM_ZERO_CNT = CW'(1 << IMMW);
  localparam logic [CW-1:0] ONE_STEP     = CW'(1);

  always_comb begin
    if (mem_form) begin
      cnt = ONE_STEP;
    end else if (use_reg) begin
      cnt = reg_val;
    end else if (imm == '0) begin
      cnt = IMM_ZERO_CNT;
    end else begin
      cnt = CW'(imm);
    end
  end

endmodule

// File: rtl/shr_step.sv
module shr_step
  import shr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] val,
  input  logic          x,
  input  shr_kind_e     kind,
  input  logic          left,
  input  shr_size_e     size,
  output logic [DW-1:0] nval,
  output logic          out_bit,
  output logic          msb_flip
);

  localparam int NL = 3;

  logic [NL-1:0][DW-1:0] l_res;
  logic [NL-1:0]         l_out;
  logic [NL-1:0]         l_flip;

  for (genvar g = 0; g < NL; g++) begin : g_lane
    localparam int W = DW >> (NL - 1 - g);
    logic [W-1:0] v;
    logic [W-1:0] r;
    logic         o;
    logic         f;

    assign v = val[W-1:0];

    always_comb begin
      if (left) begin
        o = v[W-1];
        case (kind)
          K_ROT:   f = v[W-1];
          K_ROTX:  f = x;
          default: f = 1'b0;
        endcase
        r = {v[W-2:0], f};
      end else begin
        o = v[0];
        case (kind)
          K_ARITH: f = v[W-1];
          K_ROT:   f = v[0];
          K_ROTX:  f = x;
          default: f = 1'b0;
        endcase
        r = {f, v[W-1:1]};
      end
    end

    if (W < DW) begin : g_keep
      assign l_res[g] = {val[DW-1:W], r};
    end else begin : g_full
      assign l_res[g] = r;
    end

    assign l_out[g]  = o;
    assign l_flip[g] = r[W-1] ^ v[W-1];
  end

  always_comb begin
    case (size)
      SZ_B: begin
        nval     = l_res[0];
        out_bit  = l_out[0];
        msb_flip = l_flip[0];
      end
      SZ_W: begin
        nval     = l_res[1];
        out_bit  = l_out[1];
        msb_flip = l_flip[1];
      end
      default: begin
        nval     = l_res[2];
        out_bit  = l_out[2];
        msb_flip = l_flip[2];
      end
    endcase
  end

endmodule

// File: rtl/shr_flags.sv
module shr_flags
  import shr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] res,
  input  shr_size_e     size,
  input  shr_kind_e     kind,
  input  logic          zero_cnt,
  input  logic          last_out,
  input  logic          x_run,
  input  logic          v_acc,
  output shr_flags_t    flg
);

  localparam int WB = DW / 4;
  localparam int WW = DW / 2;

  always_comb begin
    case (size)
      SZ_B: begin
        flg.n = res[WB-1];
        flg.z = (res[WB-1:0] == '0);
      end
      SZ_W: begin
        flg.n = res[WW-1];
        flg.z = (res[WW-1:0] == '0);
      end
      default: begin
        flg.n = res[DW-1];
        flg.z = (res == '0);
      end
    endcase
    flg.x = x_run;
    flg.v = (kind == K_ARITH) && v_acc;
    if (zero_cnt) begin
      flg.c = (kind == K_ROTX) ? x_run : 1'b0;
    end else begin
      flg.c = last_out;
    end
  end

endmodule

// File: rtl/shr_unit.sv
module shr_unit
  import shr_pkg::*;
#(
  parameter int DW   = 32,
  parameter int CW   = 6,
  parameter int IMMW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [DW-1:0]   opnd,
  input  logic            x_in,
  input  logic [1:0]      kind,
  input  logic            left,
  input  logic [1:0]      size,
  input  logic            cnt_is_reg,
  input  logic [IMMW-1:0] cnt_imm,
  input  logic [DW-1:0]   cnt_reg,
  input  logic            mem_form,
  output logic            busy,
  output logic            done,
  output logic [DW-1:0]   result,
  output logic            x_out,
  output logic            n_out,
  output logic            z_out,
  output logic            v_out,
  output logic            c_out
);

  localparam logic [CW-1:0] DEC_ONE = CW'(1);

  shr_state_e    state_q, state_d;
  logic [DW-1:0] val_q;
  logic [CW-1:0] rem_q;
  logic          zc_q;
  logic          x_q;
  logic          last_q;
  logic          vacc_q;
  shr_kind_e     kind_q;
  logic          left_q;
  shr_size_e     size_q;
  logic [DW-1:0] res_q;
  shr_flags_t    flg_q;
  logic          done_q;

  logic [CW-1:0] cnt_dec;
  shr_size_e     eff_size;
  logic [DW-1:0] stp_res;
  logic          stp_out;
  logic          stp_flip;
  shr_flags_t    flg_calc;
  logic          ld_en, step_en, fin_en;
  logic          unused_cnt_hi;

  assign unused_cnt_hi = ^cnt_reg[DW-1:CW];
  assign eff_size      = mem_form ? SZ_W : shr_size_e'(size);

  shr_count_dec #(.CW(CW), .IMMW(IMMW)) u_cnt (
    .use_reg  (cnt_is_reg),
    .mem_form (mem_form),
    .imm      (cnt_imm),
    .reg_val  (cnt_reg[CW-1:0]),
    .cnt      (cnt_dec)
  );

  shr_step #(.DW(DW)) u_step (
    .val      (val_q),
    .x        (x_q),
    .kind     (kind_q),
    .left     (left_q),
    .size     (size_q),
    .nval     (stp_res),
    .out_bit  (stp_out),
    .msb_flip (stp_flip)
  );

  shr_flags #(.DW(DW)) u_flags (
    .res      (val_q),
    .size     (size_q),
    .kind     (kind_q),
    .zero_cnt (zc_q),
    .last_out (last_q),
    .x_run    (x_q),
    .v_acc    (vacc_q),
    .flg      (flg_calc)
  );

  // next-state and enables
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start)        state_d = ST_RUN;
      ST_RUN:  if (rem_q == '0)  state_d = ST_IDLE;
      default:                   state_d = ST_IDLE;
    endcase
    ld_en   = (state_q == ST_IDLE) && start;
    step_en = (state_q == ST_RUN) && (rem_q != '0);
    fin_en  = (state_q == ST_RUN) && (rem_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // working registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q  <= '0;
      rem_q  <= '0;
      zc_q   <= 1'b0;
      x_q    <= 1'b0;
      last_q <= 1'b0;
      vacc_q <= 1'b0;
      kind_q <= K_ARITH;
      left_q <= 1'b0;
      size_q <= SZ_B;
    end else if (ld_en) begin
      val_q  <= opnd;
      rem_q  <= cnt_dec;
      zc_q   <= (cnt_dec == '0);
      x_q    <= x_in;
      last_q <= 1'b0;
      vacc_q <= 1'b0;
      kind_q <= shr_kind_e'(kind);
      left_q <= left;
      size_q <= eff_size;
    end else if (step_en) begin
      val_q  <= stp_res;
      rem_q  <= rem_q - DEC_ONE;
      last_q <= stp_out;
      vacc_q <= vacc_q | stp_flip;
      if (kind_q != K_ROT) x_q <= stp_out;
    end
  end

  // output registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      flg_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= fin_en;
      if (fin_en) begin
        res_q <= val_q;
        flg_q <= flg_calc;
      end
    end
  end

  assign busy   = (state_q == ST_RUN);
  assign done   = done_q;
  assign result = res_q;
  assign x_out  = flg_q.x;
  assign n_out  = flg_q.n;
  assign z_out  = flg_q.z;
  assign v_out  = flg_q.v;
  assign c_out  = flg_q.c;

  // R1
  imm_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && !cnt_is_reg && !mem_form) |=> (rem_q >= CW'(1) && rem_q <= CW'(8)));

  // R10
  mem_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && mem_form) |=> (rem_q == DEC_ONE && size_q == SZ_W));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R6
  rot_x_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && kind_q == K_ROT) |=> (x_q == $past(x_q)));

  // R7
  rotx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && zc_q && kind_q == K_ROTX) |-> (c_out == x_out));

  // R8
  v_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && kind_q != K_ARITH) |-> !v_out);

  // R12
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && rem_q != '0) |=> (busy && $stable(kind_q) && $stable(left_q)));

endmodule

// File: tb/sim_shr_unit.sv
`timescale 1ns/1ps
module sim_shr_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [31:0] opnd;
  logic        x_in;
  logic [1:0]  kind;
  logic        left;
  logic [1:0]  size;
  logic        cnt_is_reg;
  logic [2:0]  cnt_imm;
  logic [31:0] cnt_reg;
  logic        mem_form;
  logic        busy, done;
  logic [31:0] result;
  logic        x_out, n_out, z_out, v_out, c_out;

  int total = 0;
  int bad   = 0;
  logic [31:0] g_res;
  logic [4:0]  g_flg;
  int          g_lat;
  bit          g_busy_ok;

  always #4 clk = ~clk;

  shr_unit u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .opnd(opnd), .x_in(x_in),
    .kind(kind), .left(left), .size(size), .cnt_is_reg(cnt_is_reg),
    .cnt_imm(cnt_imm), .cnt_reg(cnt_reg), .mem_form(mem_form),
    .busy(busy), .done(done), .result(result), .x_out(x_out),
    .n_out(n_out), .z_out(z_out), .v_out(v_out), .c_out(c_out)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // kind codes: 0 arith, 1 logical, 2 rotate-extend, 3 rotate; flags {x,n,z,v,c}
  task automatic run_op(input int k, input bit l, input int s, input bit ureg,
                        input int imm, input logic [31:0] regv, input bit mem,
                        input logic [31:0] op, input bit xi);
    @(negedge clk);
    kind = 2'(k); left = l; size = 2'(s); cnt_is_reg = ureg; cnt_imm = 3'(imm);
    cnt_reg = regv; mem_form = mem; opnd = op; x_in = xi; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    g_lat = 0;
    g_busy_ok = 1'b1;
    do begin
      @(posedge clk); #1;
      g_lat++;
      if (!done && !busy) g_busy_ok = 1'b0;
    end while (!done && g_lat < 300);
    g_res = result;
    g_flg = {x_out, n_out, z_out, v_out, c_out};
  endtask

  function automatic void model(input int k, input bit l, input int s, input int cnt,
                                input logic [31:0] op, input bit xi,
                                output logic [31:0] r, output logic [4:0] f);
    int w;
    logic [31:0] m, v;
    bit x, c, vv, o, msb;
    w = (s == 0) ? 8 : (s == 1) ? 16 : 32;
    m = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1);
    v = op & m; x = xi; c = 1'b0; vv = 1'b0;
    for (int i = 0; i < cnt; i++) begin
      msb = v[w-1];
      if (l) begin
        o = v[w-1];
        v = (v << 1) & m;
        if (k == 3) v[0] = o;
        else if (k == 2) v[0] = x;
      end else begin
        o = v[0];
        v = v >> 1;
        if (k == 0) v[w-1] = msb;
        else if (k == 3) v[w-1] = o;
        else if (k == 2) v[w-1] = x;
      end
      if (k != 3) x = o;
      c = o;
      if (v[w-1] != msb) vv = 1'b1;
    end
    if (cnt == 0) c = (k == 2) ? xi : 1'b0;
    if (k != 0) vv = 1'b0;
    r = (op & ~m) | v;
    f = {x, v[w-1], (v == 0), vv, c};
  endfunction

  task automatic t_reset;
    chk("R13 busy", busy, 0);
    chk("R13 done", done, 0);
    chk("R13 result", result, 0);
    chk("R13 flags", {x_out, n_out, z_out, v_out, c_out}, 0);
  endtask

  task automatic t_count_imm; // R1
    run_op(1, 0, 2, 0, 0, 0, 0, 32'h8000_0001, 0);
    chk("R1 imm0 means 8 result", g_res, 32'h0080_0000);
    chk("R1 imm0 latency", g_lat, 9);
    run_op(1, 1, 2, 0, 5, 0, 0, 32'h0000_0001, 0);
    chk("R1 imm5 result", g_res, 32'h0000_0020);
    run_op(3, 0, 1, 1, 0, 32'h0000_0041, 0, 32'h0000_0001, 0);
    chk("R1 reg mod 64 result", g_res, 32'h0000_8000);
    chk("R6 rot flags", g_flg, 5'b01001);
  endtask

  task automatic t_basic; // R2 R5
    run_op(0, 1, 0, 0, 1, 0, 0, 32'h0000_0040, 0);
    chk("R2 asl byte result", g_res, 32'h0000_0080);
    chk("R5 asl byte flags", g_flg, 5'b01010);
    run_op(2, 1, 0, 0, 1, 0, 0, 32'h0000_0080, 0);
    chk("R7 roxl result", g_res, 32'h0000_0000);
    chk("R7 roxl flags", g_flg, 5'b10101);
  endtask

  task automatic t_large; // R3
    run_op(0, 0, 0, 1, 0, 32'd40, 0, 32'h0000_0080, 0);
    chk("R3 asr sign fill", g_res, 32'h0000_00FF);
    chk("R3 asr flags", g_flg, 5'b11001);
    run_op(1, 1, 1, 1, 0, 32'd20, 0, 32'h0000_1234, 1);
    chk("R3 lsl beyond width", g_res, 32'h0000_0000);
    chk("R3 lsl flags", g_flg, 5'b00100);
    run_op(2, 0, 0, 1, 0, 32'd9, 0, 32'h0000_005A, 1);
    chk("R3 roxr width+1", g_res, 32'h0000_005A);
    chk("R7 roxr width+1 flags", g_flg, 5'b10001);
    run_op(3, 1, 0, 1, 0, 32'd8, 0, 32'h0000_005A, 1);
    chk("R3 rol width", g_res, 32'h0000_005A);
    chk("R6 rol width flags", g_flg, 5'b10000);
  endtask

  task automatic t_upper; // R4
    run_op(1, 1, 0, 0, 1, 0, 0, 32'hABCD_EF01, 0);
    chk("R4 byte upper kept", g_res, 32'hABCD_EF02);
    run_op(0, 0, 1, 0, 1, 0, 0, 32'hABCD_8001, 0);
    chk("R4 word upper kept", g_res, 32'hABCD_C000);
    chk("R5 asr word flags", g_flg, 5'b11001);
  endtask

  task automatic t_zero; // R5 R6 R7 zero count
    run_op(2, 1, 0, 1, 0, 32'd64, 0, 32'h0000_0000, 1);
    chk("R7 zero count result", g_res, 32'h0);
    chk("R7 zero count flags", g_flg, 5'b10101);
    chk("R11 zero count latency", g_lat, 1);
    run_op(0, 1, 2, 1, 0, 32'd0, 0, 32'h8000_0000, 1);
    chk("R5 zero count flags", g_flg, 5'b11000);
    run_op(3, 0, 2, 1, 0, 32'd128, 0, 32'h0000_0001, 1);
    chk("R6 zero count flags", g_flg, 5'b10000);
  endtask

  task automatic t_ovf; // R8
    run_op(0, 1, 0, 0, 2, 0, 0, 32'h0000_0020, 0);
    chk("R8 asl late flip", g_flg, 5'b01010);
    run_op(0, 1, 0, 0, 1, 0, 0, 32'h0000_00C0, 0);
    chk("R8 asl no flip", g_flg, 5'b11001);
    run_op(0, 1, 0, 0, 2, 0, 0, 32'h0000_0060, 0);
    chk("R8 asl sticky", g_flg, 5'b11011);
    run_op(1, 1, 0, 0, 1, 0, 0, 32'h0000_0040, 0);
    chk("R8 lsl v clear", g_flg, 5'b01000);
  endtask

  task automatic t_nz; // R9
    run_op(1, 0, 2, 1, 0, 32'd17, 0, 32'h0001_0000, 0);
    chk("R9 long zero", g_res, 32'h0);
    chk("R9 long zero flags", g_flg, 5'b10101);
    run_op(1, 0, 0, 0, 2, 0, 0, 32'hFF00_0002, 0);
    chk("R9 byte zero result", g_res, 32'hFF00_0000);
    chk("R9 byte zero flags", g_flg, 5'b10101);
  endtask

  task automatic t_mem; // R10
    run_op(0, 1, 0, 0, 5, 32'd33, 1, 32'h0001_8000, 0);
    chk("R10 mem result", g_res, 32'h0001_0000);
    chk("R10 mem flags", g_flg, 5'b10111);
    chk("R10 mem latency", g_lat, 2);
  endtask

  task automatic t_timing; // R11
    run_op(1, 0, 2, 0, 3, 0, 0, 32'h0000_00F0, 0);
    chk("R11 latency", g_lat, 4);
    chk("R11 busy while running", g_busy_ok, 1);
    @(posedge clk); #1;
    chk("R11 done single cycle", done, 0);
    chk("R11 result held", result, 32'h0000_001E);
  endtask

  task automatic t_busy_start; // R12
    int lat;
    @(negedge clk);
    kind = 2'd1; left = 1'b1; size = 2'd2; cnt_is_reg = 1'b0; cnt_imm = 3'd5;
    mem_form = 1'b0; opnd = 32'h1; x_in = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk); @(negedge clk);
    opnd = 32'hFFFF_FFFF; kind = 2'd0; left = 1'b0; cnt_imm = 3'd1; start = 1'b1;
    @(negedge clk); start = 1'b0;
    lat = 3;
    while (!done && lat < 100) begin @(posedge clk); #1; lat++; end
    chk("R12 first op latency", lat, 6);
    chk("R12 first op result", result, 32'h0000_0020);
    for (int i = 0; i < 10; i++) begin
      @(posedge clk); #1;
      if (done) chk("R12 extra done", done, 0);
    end
    chk("R12 no extra done", done, 0);
  endtask

  task automatic t_sweep; // R2 exhaustive kinds, directions, sizes
    int cnts[13] = '{0, 1, 3, 7, 8, 9, 15, 16, 17, 31, 32, 33, 63};
    logic [31:0] er;
    logic [4:0]  ef;
    logic [31:0] pat;
    for (int k = 0; k < 4; k++)
      for (int l = 0; l < 2; l++)
        for (int s = 0; s < 3; s++)
          for (int j = 0; j < 13; j++) begin
            pat = 32'h9C3A_B561 ^ (32'(k * 7 + j) << (j % 9));
            run_op(k, l[0], s, 1, 0, 32'(cnts[j]) | 32'h0000_0C00, 0, pat, j[0]);
            model(k, l[0], s, cnts[j], pat, j[0], er, ef);
            chk("R2 sweep result", g_res, er);
            chk("R2 sweep flags", g_flg, ef);
            chk("R11 sweep latency", g_lat, cnts[j] + 1);
          end
  endtask

  initial begin
    #1200000;
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; opnd = '0; x_in = 1'b0; kind = '0; left = 1'b0;
    size = '0; cnt_is_reg = 1'b0; cnt_imm = '0; cnt_reg = '0; mem_form = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_count_imm();
    t_basic();
    t_large();
    t_upper();
    t_zero();
    t_ovf();
    t_nz();
    t_mem();
    t_timing();
    t_busy_start();
    t_sweep();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule